// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block joins two parallel buses, side A and side B, and can pass data in either direction, either as it arrives or from a holding register. Each transfer direction has its own bank of capture registers. The A-to-B bank samples the A bus, and the B-to-A bank samples the B bus. A per-direction select picks, for the bus being driven, between live data from the opposite bus and the contents of that direction's register. The width is split into byte lanes. Every lane has its own capture strobes, selects and enables, so tying the lane controls together gives full-width operation.

The pads are not modelled as true tri-state pins. Each bus appears as an input vector, an output vector and a per-lane drive-enable. The capture strobes are ordinary inputs sampled by one common system clock. A register loads on the first system clock edge at which its lane strobe is seen high after being low.

When a lane drives both buses in live mode, the two live paths would form a loop. In that case a per-lane keeper returns the last value each bus carried, and the buses hold their state.

Top module: `regbus_xcvr`

## Requirements
- R1: After the active-low reset `rst_n` is released, every capture register and every keeper holds zero. With both directions enabled in stored mode, both outputs read zero until a capture occurs.
- R2: A lane register loads only on a low-to-high change of its strobe (`cap_ab` for the A-side register, `cap_ba` for the B-side register). The change is seen at the system clock edge. Holding a strobe high, or holding it low, never reloads the register.
- R3: A capture happens on every strobe rise, whatever the values of the selects and enables, including when the lane is fully isolated.
- R4: With `sel_ab` = 0, the driven B output carries live A data; with `sel_ab` = 1 it carries the stored A register. `sel_ba` chooses in the same way for the A output, using B data.
- R5: `en_ab` is active high and sets `b_oe` for its lane. `en_ba_n` is active low and sets `a_oe` for its lane. The output data of an undriven lane is zero. With `en_ab` = 0 and `en_ba_n` = 1, both buses of the lane are undriven.
- R6: Lanes are independent. Lane k occupies data bits [8k+7:8k] and control bit k. Different lanes may run different modes in the same cycle.
- R7: With both enables asserted and both selects at 0, each bus of the lane is driven with the last value that bus carried before this mode began. External inputs are ignored. A capture in this mode stores the held value.
- R8: Capture samples the bus as it actually is. When the block drives a bus, the register facing that bus loads the driven value. So, with B driven live from A, a rise on `cap_ba` loads the A value into the B-side register, and the mirrored case holds as well.
- R9: With both enables asserted and both selects at 1, the B output carries the stored A register and the A output carries the stored B register, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | LANES*LANE_W | Value present on the A bus from outside |
| a_out | output | LANES*LANE_W | Value the block drives onto the A bus |
| a_oe | output | LANES | Per-lane drive enable for the A bus |
| b_in | input | LANES*LANE_W | Value present on the B bus from outside |
| b_out | output | LANES*LANE_W | Value the block drives onto the B bus |
| b_oe | output | LANES | Per-lane drive enable for the B bus |
| cap_ab | input | LANES | Per-lane strobe loading the A-side register |
| cap_ba | input | LANES | Per-lane strobe loading the B-side register |
| sel_ab | input | LANES | B output source: 0 live A, 1 stored A |
| sel_ba | input | LANES | A output source: 0 live B, 1 stored B |
| en_ab | input | LANES | Active-high enable for driving the B bus |
| en_ba_n | input | LANES | Active-low enable for driving the A bus |

## Verification
The bench keeps a strobe high across several clock edges. A design that captures on level instead of on a rise would then replace the stored value with later bus data. It captures while a lane is isolated and while the selects point elsewhere, which catches a design that gates capture with the controls. It also captures while the block drives the bus, so a design that samples the raw input pins instead of the driven bus value would store the ignored external data. The keeper mode is entered after a different prior value on each bus and then fed changing inputs: a design that lets either input through, or that makes both buses share one held value, shows the wrong data. One lane is kept in that mode while its neighbour is isolated, exposing any mixing of controls across lanes.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

   // Source of the value a bus carries in one lane
   typedef enum logic [2:0] {
      SRC_PIN     = 3'd0,   // externally driven input of this bus
      SRC_HOLD    = 3'd1,   // keeper value of this bus
      SRC_REG_A   = 3'd2,   // A-side capture register
      SRC_REG_B   = 3'd3,   // B-side capture register
      SRC_FAR_PIN = 3'd4    // external input of the opposite bus
   } bus_src_t;

endpackage

// File: rtl/regbus_edge.sv
module regbus_edge #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] strobe,
   output logic [N-1:0] rise
);

   logic [N-1:0] strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= '0;
      else        strobe_q <= strobe;
   end

   assign rise = strobe & ~strobe_q;

endmodule

// File: rtl/regbus_lane_dec.sv
module regbus_lane_dec
   import regbus_pkg::*;
(
   input  logic     sel_ab,
   input  logic     sel_ba,
   input  logic     en_ab,
   input  logic     en_ba_n,
   output logic     drive_a,
   output logic     drive_b,
   output logic     hold,
   output bus_src_t a_src,
   output bus_src_t b_src
);

   always_comb begin
      drive_a = ~en_ba_n;
      drive_b = en_ab;
      hold    = drive_a & drive_b & ~sel_ab & ~sel_ba;

      if (!drive_a)     a_src = SRC_PIN;
      else if (hold)    a_src = SRC_HOLD;
      else if (sel_ba)  a_src = SRC_REG_B;
      else if (drive_b) a_src = SRC_REG_A;    // B carries stored A, A repeats it
      else              a_src = SRC_FAR_PIN;

      if (!drive_b)     b_src = SRC_PIN;
      else if (hold)    b_src = SRC_HOLD;
      else if (sel_ab)  b_src = SRC_REG_A;
      else if (drive_a) b_src = SRC_REG_B;    // A carries stored B, B repeats it
      else              b_src = SRC_FAR_PIN;
   end

endmodule

// File: rtl/regbus_lane.sv
module regbus_lane
   import regbus_pkg::*;
#(
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANE_W-1:0] a_in,
   input  logic [LANE_W-1:0] b_in,
   input  logic              load_a,
   input  logic              load_b,
   input  logic              sel_ab,
   input  logic              sel_ba,
   input  logic              en_ab,
   input  logic              en_ba_n,
   output logic [LANE_W-1:0] a_out,
   output logic [LANE_W-1:0] b_out,
   output logic              a_oe,
   output logic              b_oe
);

   logic              drive_a, drive_b, hold;
   bus_src_t          a_src, b_src;
   logic [LANE_W-1:0] reg_a, reg_b, keep_a, keep_b;
   logic [LANE_W-1:0] a_bus, b_bus;

   regbus_lane_dec i_dec (
      .sel_ab  (sel_ab),
      .sel_ba  (sel_ba),
      .en_ab   (en_ab),
      .en_ba_n (en_ba_n),
      .drive_a (drive_a),
      .drive_b (drive_b),
      .hold    (hold),
      .a_src   (a_src),
      .b_src   (b_src)
   );

   function automatic logic [LANE_W-1:0] pick(
      input bus_src_t          src,
      input logic [LANE_W-1:0] own_pin,
      input logic [LANE_W-1:0] far_pin,
      input logic [LANE_W-1:0] held,
      input logic [LANE_W-1:0] ra,
      input logic [LANE_W-1:0] rb
   );
      case (src)
         SRC_PIN:     pick = own_pin;
         SRC_HOLD:    pick = held;
         SRC_REG_A:   pick = ra;
         SRC_REG_B:   pick = rb;
         SRC_FAR_PIN: pick = far_pin;
         default:     pick = '0;
      endcase
   endfunction

   // Resolved value actually present on each bus of this lane
   assign a_bus = pick(a_src, a_in, b_in, keep_a, reg_a, reg_b);
   assign b_bus = pick(b_src, b_in, a_in, keep_b, reg_a, reg_b);

   assign a_out = drive_a ? a_bus : '0;
   assign b_out = drive_b ? b_bus : '0;
   assign a_oe  = drive_a;
   assign b_oe  = drive_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_a <= '0;
         reg_b <= '0;
      end else begin
         if (load_a) reg_a <= a_bus;
         if (load_b) reg_b <= b_bus;
      end
   end

   // Keeper follows the buses except while the lane closes the loop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep_a <= '0;
         keep_b <= '0;
      end else if (!hold) begin
         keep_a <= a_bus;
         keep_b <= b_bus;
      end
   end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES*LANE_W-1:0] a_in,
   output logic [LANES*LANE_W-1:0] a_out,
   output logic [LANES-1:0]        a_oe,
   input  logic [LANES*LANE_W-1:0] b_in,
   output logic [LANES*LANE_W-1:0] b_out,
   output logic [LANES-1:0]        b_oe,
   input  logic [LANES-1:0]        cap_ab,
   input  logic [LANES-1:0]        cap_ba,
   input  logic [LANES-1:0]        sel_ab,
   input  logic [LANES-1:0]        sel_ba,
   input  logic [LANES-1:0]        en_ab,
   input  logic [LANES-1:0]        en_ba_n
);

   localparam int unsigned BUS_W = LANES * LANE_W;

   if (LANES < 1 || LANES > 64) begin : g_bad_lanes
      $error("regbus_xcvr: LANES must be 1..64");
   end
   if (LANE_W < 1 || BUS_W > 1024) begin : g_bad_width
      $error("regbus_xcvr: LANE_W out of range");
   end

   logic [LANES-1:0] rise_ab, rise_ba;

   regbus_edge #(.N(LANES)) i_edge_ab (
      .clk (clk), .rst_n (rst_n), .strobe (cap_ab), .rise (rise_ab)
   );

   regbus_edge #(.N(LANES)) i_edge_ba (
      .clk (clk), .rst_n (rst_n), .strobe (cap_ba), .rise (rise_ba)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      regbus_lane #(.LANE_W(LANE_W)) i_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .a_in    (a_in[l*LANE_W +: LANE_W]),
         .b_in    (b_in[l*LANE_W +: LANE_W]),
         .load_a  (rise_ab[l]),
         .load_b  (rise_ba[l]),
         .sel_ab  (sel_ab[l]),
         .sel_ba  (sel_ba[l]),
         .en_ab   (en_ab[l]),
         .en_ba_n (en_ba_n[l]),
         .a_out   (a_out[l*LANE_W +: LANE_W]),
         .b_out   (b_out[l*LANE_W +: LANE_W]),
         .a_oe    (a_oe[l]),
         .b_oe    (b_oe[l])
      );
   end

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [LANES*LANE_W-1:0] a_in,
   input logic [LANES*LANE_W-1:0] a_out,
   input logic [LANES-1:0]        a_oe,
   input logic [LANES*LANE_W-1:0] b_in,
   input logic [LANES*LANE_W-1:0] b_out,
   input logic [LANES-1:0]        b_oe,
   input logic [LANES-1:0]        cap_ab,
   input logic [LANES-1:0]        cap_ba,
   input logic [LANES-1:0]        sel_ab,
   input logic [LANES-1:0]        sel_ba,
   input logic [LANES-1:0]        en_ab,
   input logic [LANES-1:0]        en_ba_n
);

   for (genvar l = 0; l < LANES; l++) begin : g_chk
      logic loop_m, stored_b;
      assign loop_m   = en_ab[l] & ~en_ba_n[l] & ~sel_ab[l] & ~sel_ba[l];
      assign stored_b = en_ab[l] & sel_ab[l];

      // R5: undriven lanes present zero data
      a_r5_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !b_oe[l] |-> (b_out[l*LANE_W +: LANE_W] == '0));
      a_r5_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !a_oe[l] |-> (a_out[l*LANE_W +: LANE_W] == '0));

      // R4: one-way live transfer copies the far input
      a_r4_live_ab: assert property (@(posedge clk) disable iff (!rst_n)
         (en_ab[l] && !sel_ab[l] && en_ba_n[l]) |->
            (b_out[l*LANE_W +: LANE_W] == a_in[l*LANE_W +: LANE_W]));
      a_r4_live_ba: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_ba_n[l] && !sel_ba[l] && !en_ab[l]) |->
            (a_out[l*LANE_W +: LANE_W] == b_in[l*LANE_W +: LANE_W]));

      // R7: keeper mode holds both buses steady
      a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
         loop_m |=> (!loop_m ||
            ($stable(a_out[l*LANE_W +: LANE_W]) && $stable(b_out[l*LANE_W +: LANE_W]))));

      // R2: no strobe rise means the stored value on B does not move
      a_r2_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
         (stored_b && !cap_ab[l]) |=> (!stored_b || $stable(b_out[l*LANE_W +: LANE_W])));
   end

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) i_chk (.*);

// File: tb/test_regbus_xcvr.sv
`timescale 1ns/1ps
module test_regbus_xcvr;

   localparam int L = 2;
   localparam int W = 8;
   localparam int BW = L * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [BW-1:0] a_in = '0, b_in = '0;
   logic [BW-1:0] a_out, b_out;
   logic [L-1:0]  a_oe, b_oe;
   logic [L-1:0]  cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0;
   logic [L-1:0]  en_ab = '0, en_ba_n = '1;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   typedef struct {
      string         tag;
      logic [BW-1:0] xa, xb;
      logic [L-1:0]  xaoe, xboe;
   } exp_t;

   exp_t exp_q[$];

   always #2.5 clk = ~clk;   // 200 MHz

   regbus_xcvr #(.LANES(L), .LANE_W(W)) i_regbus_xcvr (
      .clk (clk), .rst_n (rst_n),
      .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
      .b_in (b_in), .b_out (b_out), .b_oe (b_oe),
      .cap_ab (cap_ab), .cap_ba (cap_ba),
      .sel_ab (sel_ab), .sel_ba (sel_ba),
      .en_ab (en_ab), .en_ba_n (en_ba_n)
   );

   // Driver: apply one cycle of stimulus and queue the expected outputs
   task automatic step(input logic [L-1:0] cab, cba, eab, sab, eban, sba,
                       input logic [BW-1:0] ai, bi, xa, xb,
                       input logic [L-1:0] xaoe, xboe, input string tag);
      exp_t e;
      @(negedge clk);
      cap_ab = cab; cap_ba = cba; en_ab = eab; sel_ab = sab;
      en_ba_n = eban; sel_ba = sba; a_in = ai; b_in = bi;
      e.tag = tag; e.xa = xa; e.xb = xb; e.xaoe = xaoe; e.xboe = xboe;
      exp_q.push_back(e);
   endtask

   // Monitor: sample between edges and compare against the queue
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            compared++;
            if (a_out !== e.xa || b_out !== e.xb || a_oe !== e.xaoe || b_oe !== e.xboe) begin
               mismatched++;
               $display("FAIL %s: a_out=%h b_out=%h a_oe=%b b_oe=%b expected a_out=%h b_out=%h a_oe=%b b_oe=%b",
                        e.tag, a_out, b_out, a_oe, b_oe, e.xa, e.xb, e.xaoe, e.xboe);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      //    cab    cba    eab    sab    eban   sba    a_in      b_in      x_a       x_b       aoe    boe
      step(2'b00,2'b00,2'b11,2'b11,2'b00,2'b11,16'h1234,16'h5678,16'h0000,16'h0000,2'b11,2'b11,"R1 reset clears registers");
      step(2'b00,2'b00,2'b00,2'b00,2'b11,2'b00,16'hA1A2,16'hB1B2,16'h0000,16'h0000,2'b00,2'b00,"R5 isolation");
      step(2'b00,2'b00,2'b11,2'b00,2'b11,2'b00,16'h3C4D,16'hFFFF,16'h0000,16'h3C4D,2'b00,2'b11,"R4 live A to B");
      step(2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,16'h1111,16'h9E8F,16'h9E8F,16'h0000,2'b11,2'b00,"R4 live B to A");
      // R3: capture while isolated and with selects at stored
      step(2'b11,2'b00,2'b00,2'b11,2'b11,2'b00,16'hC3A5,16'h0000,16'h0000,16'h0000,2'b00,2'b00,"R3 capture while isolated");
      step(2'b11,2'b00,2'b11,2'b11,2'b11,2'b00,16'h0F0F,16'h0000,16'h0000,16'hC3A5,2'b00,2'b11,"R3 stored A after isolated capture");
      step(2'b00,2'b00,2'b11,2'b11,2'b11,2'b00,16'h7777,16'h0000,16'h0000,16'hC3A5,2'b00,2'b11,"R2 held strobe does not reload");
      // R6: capture only lane 0 of the B-side register
      step(2'b00,2'b01,2'b00,2'b00,2'b11,2'b00,16'h0000,16'h5A6B,16'h0000,16'h0000,2'b00,2'b00,"R6 lane0 B capture");
      step(2'b00,2'b01,2'b11,2'b11,2'b00,2'b11,16'h0000,16'h0000,16'h006B,16'hC3A5,2'b11,2'b11,"R9 exchange stored data");
      step(2'b00,2'b00,2'b10,2'b00,2'b10,2'b01,16'h2E99,16'h4455,16'h006B,16'h2E00,2'b01,2'b10,"R6 mixed lane modes");
      // R8: B driven live from A, both registers clocked
      step(2'b11,2'b11,2'b11,2'b00,2'b11,2'b00,16'hD00D,16'h0000,16'h0000,16'hD00D,2'b00,2'b11,"R8 live A with both strobes");
      step(2'b11,2'b11,2'b11,2'b11,2'b00,2'b11,16'h0000,16'h0000,16'hD00D,16'hD00D,2'b11,2'b11,"R8 A value in both registers");
      step(2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,16'h0000,16'hBEEF,16'hBEEF,16'h0000,2'b11,2'b00,"R4 live B to A again");
      step(2'b11,2'b00,2'b00,2'b00,2'b00,2'b00,16'h0000,16'hBEEF,16'hBEEF,16'h0000,2'b11,2'b00,"R8 A-side capture of driven A bus");
      step(2'b11,2'b00,2'b11,2'b11,2'b00,2'b11,16'h0000,16'h0000,16'hD00D,16'hBEEF,2'b11,2'b11,"R8 mirrored store");
      // R7: keeper
      step(2'b00,2'b00,2'b11,2'b00,2'b11,2'b00,16'h1357,16'h0000,16'h0000,16'h1357,2'b00,2'b11,"R7 prepare keeper");
      step(2'b00,2'b00,2'b11,2'b00,2'b00,2'b00,16'hFFFF,16'h0000,16'h1357,16'h1357,2'b11,2'b11,"R7 keeper entry");
      step(2'b00,2'b00,2'b11,2'b00,2'b00,2'b00,16'hAAAA,16'h5555,16'h1357,16'h1357,2'b11,2'b11,"R7 keeper ignores inputs");
      step(2'b11,2'b00,2'b11,2'b00,2'b00,2'b00,16'h0000,16'h0000,16'h1357,16'h1357,2'b11,2'b11,"R7 capture in keeper mode");
      step(2'b11,2'b00,2'b11,2'b11,2'b11,2'b00,16'h0042,16'h0000,16'h0000,16'h1357,2'b00,2'b11,"R7 stored held value");
      step(2'b00,2'b00,2'b01,2'b00,2'b10,2'b00,16'h7700,16'h0066,16'h0042,16'h0057,2'b01,2'b01,"R6 R7 per-lane keeper");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule